// File: doc/BRIEF.md
# Event Timer Channel with Sticky Flags

A single timer channel that counts events from one selectable source. Three sources are available: an internal event on every second system clock edge, the rising edge of an asynchronous external input, or a tick pulse from a prescaler that sits outside this block. Software writes a start value and a match value. When the channel is turned on, the counter is loaded with the start value and advances by one on each event. After (match − start + 1) events it raises a sticky match flag and reloads the start value. If the count passes from all ones to zero, it raises a sticky wrap flag instead.

Software reaches the channel through a small register bus with a two-bit select. Each flag can be cleared in three ways: by writing a one to its bit, by pulsing its interrupt acknowledge strobe, or by turning the channel off. Each flag drives an interrupt request, gated by its own enable bit.

Top module: `evt_timer`

## Requirements
- R1: After reset both flags and both interrupt requests are low, and the control word, start value, match value and count all read as zero.
- R2: Control word layout (select 0): bit 0 = channel on, bit 1 = wrap interrupt enable, bit 2 = match interrupt enable, bit 4 = external source select, bit 15 = prescaler source select, bit 20 = wrap flag, bit 21 = match flag. Every other bit reads zero, and writes to it are ignored.
- R3: A control write that turns the channel on while it is off loads the count with the start value. While the channel is off, the count holds.
- R4: With bit 15 set, each cycle with the prescaler tick high is one event, whatever bit 4 says. With bit 15 clear and bit 4 set, each rising edge of the external input is one event, counted on the third clock edge after the input is sampled high. With both bits clear, an event occurs on every second clock edge after turn-on, and the first of these is the second edge.
- R5: An event that finds the count equal to the match value sets the match flag and reloads the start value. The flag therefore rises after (match − start + 1) events.
- R6: An event that finds the count all ones, with no match, sets the wrap flag and makes the count zero. A match at all ones reloads the start value and does not set the wrap flag.
- R7: A control write with a one in bit 20 or bit 21 clears that flag. A zero in that bit leaves the flag as it is, so one write can clear one flag and keep the other.
- R8: A pulse on a flag's acknowledge strobe clears that flag.
- R9: A control write with bit 0 low clears both flags. This clear wins over a flag set in the same cycle.
- R10: A flag set from an event wins over a write-one clear or an acknowledge in the same cycle.
- R11: Each interrupt request equals its flag ANDed with its enable bit.
- R12: Select 1 reads and writes the start value, select 2 reads and writes the match value, and select 3 reads the live count (writes to select 3 are ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_evt | input | 1 | Asynchronous external event input |
| psc_tick | input | 1 | One-cycle tick from the outside prescaler |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 start, 2 match, 3 count |
| wr_data | input | 24 | Write data |
| rd_data | output | 24 | Read data for the selected register (combinational) |
| ack_ovf | input | 1 | Wrap interrupt acknowledge |
| ack_cmp | input | 1 | Match interrupt acknowledge |
| ovf_flag | output | 1 | Sticky wrap flag |
| cmp_flag | output | 1 | Sticky match flag |
| irq_ovf | output | 1 | Wrap interrupt request |
| irq_cmp | output | 1 | Match interrupt request |

## Verification
A write, an acknowledge or a prescaler tick that is present before a clock edge shows up in the flags, the count and the readback one edge later. An internal-source event lands on every second enabled edge. An external rising edge needs three edges to pass the synchroniser and the edge detector before it counts. The bench drives inputs just after each rising edge. It advances a behavioural reference model on the same edge, using the same sampled inputs and a shift history of the external input, and compares every output on the falling edge. Each result is therefore checked in exactly the cycle it is due, with no tolerance window.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int B_EN  = 0;
  localparam int B_IEO = 1;
  localparam int B_IEC = 2;
  localparam int B_EXT = 4;
  localparam int B_PSC = 15;
  localparam int B_OVF = 20;
  localparam int B_CMP = 21;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CMP  = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/evt_src.sv
module evt_src #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ext_sel,
  input  logic psc_sel,
  input  logic ext_in,
  input  logic psc_tick,
  output logic evt
);
  localparam int SH_W = SYNC + 1;

  logic [SH_W-1:0] sh_q, sh_d;
  logic            tog_q, tog_d;
  logic            ext_rise, half_tick;

  // synchroniser stages plus one history stage for edge detection
  always_comb begin
    sh_d  = {sh_q[SH_W-2:0], ext_in};
    tog_d = en ? ~tog_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      tog_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      tog_q <= tog_d;
    end
  end

  assign ext_rise  = sh_q[SYNC-1] & ~sh_q[SYNC];
  assign half_tick = en & tog_q;

  always_comb begin
    if (psc_sel)      evt = psc_tick;
    else if (ext_sel) evt = ext_rise;
    else              evt = half_tick;
  end
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic         evt,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] cnt,
  output logic         hit_cmp,
  output logic         hit_ovf
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d   = cnt_q;
    hit_cmp = 1'b0;
    hit_ovf = 1'b0;
    if (start) begin
      cnt_d = load_val;
    end else if (en && evt) begin
      if (cnt_q == cmp_val) begin
        hit_cmp = 1'b1;
        cnt_d   = load_val;
      end else begin
        hit_ovf = &cnt_q;
        cnt_d   = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R3
  load_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == $past(load_val));

  // R5
  reload_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cmp |=> cnt_q == $past(load_val));

  // R6
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ovf |=> cnt_q == '0);
endmodule

// File: rtl/evt_ctrl_regs.sv
module evt_ctrl_regs
  import evt_timer_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] wr_data,
  input  logic         ack_ovf,
  input  logic         ack_cmp,
  input  logic         hit_ovf,
  input  logic         hit_cmp,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] rd_data,
  output logic         en,
  output logic         ext_sel,
  output logic         psc_sel,
  output logic         start,
  output logic [W-1:0] load_val,
  output logic [W-1:0] cmp_val,
  output logic         ovf_flag,
  output logic         cmp_flag,
  output logic         irq_ovf,
  output logic         irq_cmp
);
  reg_sel_e     sel;
  logic         wr_ctl, dis_wr;
  logic         en_q, en_d, ieo_q, ieo_d, iec_q, iec_d;
  logic         ext_q, ext_d, psc_q, psc_d;
  logic         ovf_q, ovf_d, cmp_q, cmp_d;
  logic [W-1:0] ld_q, ld_d, cv_q, cv_d;
  logic [W-1:0] ctl_img;

  assign sel    = reg_sel_e'(reg_sel);
  assign wr_ctl = wr_en && (sel == SEL_CTL);
  assign dis_wr = wr_ctl && !wr_data[B_EN];
  assign start  = wr_ctl && wr_data[B_EN] && !en_q;

  always_comb begin
    en_d  = en_q;  ieo_d = ieo_q; iec_d = iec_q;
    ext_d = ext_q; psc_d = psc_q;
    ld_d  = ld_q;  cv_d  = cv_q;
    if (wr_ctl) begin
      en_d  = wr_data[B_EN];
      ieo_d = wr_data[B_IEO];
      iec_d = wr_data[B_IEC];
      ext_d = wr_data[B_EXT];
      psc_d = wr_data[B_PSC];
    end
    if (wr_en && sel == SEL_LOAD) ld_d = wr_data;
    if (wr_en && sel == SEL_CMP)  cv_d = wr_data;
    // clears, then set from an event, then turn-off clear dominates
    ovf_d = ovf_q;
    if ((wr_ctl && wr_data[B_OVF]) || ack_ovf) ovf_d = 1'b0;
    if (hit_ovf) ovf_d = 1'b1;
    if (dis_wr)  ovf_d = 1'b0;
    cmp_d = cmp_q;
    if ((wr_ctl && wr_data[B_CMP]) || ack_cmp) cmp_d = 1'b0;
    if (hit_cmp) cmp_d = 1'b1;
    if (dis_wr)  cmp_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0; ieo_q <= 1'b0; iec_q <= 1'b0;
      ext_q <= 1'b0; psc_q <= 1'b0;
      ovf_q <= 1'b0; cmp_q <= 1'b0;
      ld_q  <= '0;   cv_q  <= '0;
    end else begin
      en_q  <= en_d;  ieo_q <= ieo_d; iec_q <= iec_d;
      ext_q <= ext_d; psc_q <= psc_d;
      ovf_q <= ovf_d; cmp_q <= cmp_d;
      ld_q  <= ld_d;  cv_q  <= cv_d;
    end
  end

  always_comb begin
    ctl_img        = '0;
    ctl_img[B_EN]  = en_q;
    ctl_img[B_IEO] = ieo_q;
    ctl_img[B_IEC] = iec_q;
    ctl_img[B_EXT] = ext_q;
    ctl_img[B_PSC] = psc_q;
    ctl_img[B_OVF] = ovf_q;
    ctl_img[B_CMP] = cmp_q;
    case (sel)
      SEL_CTL:  rd_data = ctl_img;
      SEL_LOAD: rd_data = ld_q;
      SEL_CMP:  rd_data = cv_q;
      default:  rd_data = cnt;
    endcase
  end

  assign en       = en_q;
  assign ext_sel  = ext_q;
  assign psc_sel  = psc_q;
  assign load_val = ld_q;
  assign cmp_val  = cv_q;
  assign ovf_flag = ovf_q;
  assign cmp_flag = cmp_q;
  assign irq_ovf  = ovf_q & ieo_q;
  assign irq_cmp  = cmp_q & iec_q;

  // R9
  off_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> (!ovf_q && !cmp_q));

  // R7
  w1c_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wr_data[B_CMP] && !hit_cmp) |=> !cmp_q);

  // R8
  ack_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ovf && !hit_ovf) |=> !ovf_q);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cmp && !dis_wr) |=> cmp_q);
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int W    = 24,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_evt,
  input  logic         psc_tick,
  input  logic         wr_en,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         ack_ovf,
  input  logic         ack_cmp,
  output logic         ovf_flag,
  output logic         cmp_flag,
  output logic         irq_ovf,
  output logic         irq_cmp
);
  logic         en, ext_sel, psc_sel, start, evt, hit_cmp, hit_ovf;
  logic [W-1:0] load_val, cmp_val, cnt;

  evt_src #(.SYNC(SYNC)) src_i (
    .clk(clk), .rst_n(rst_n), .en(en), .ext_sel(ext_sel), .psc_sel(psc_sel),
    .ext_in(ext_evt), .psc_tick(psc_tick), .evt(evt)
  );

  evt_count_core #(.W(W)) core_i (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .evt(evt),
    .load_val(load_val), .cmp_val(cmp_val), .cnt(cnt),
    .hit_cmp(hit_cmp), .hit_ovf(hit_ovf)
  );

  evt_ctrl_regs #(.W(W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .ack_ovf(ack_ovf), .ack_cmp(ack_cmp),
    .hit_ovf(hit_ovf), .hit_cmp(hit_cmp), .cnt(cnt), .rd_data(rd_data),
    .en(en), .ext_sel(ext_sel), .psc_sel(psc_sel), .start(start),
    .load_val(load_val), .cmp_val(cmp_val), .ovf_flag(ovf_flag),
    .cmp_flag(cmp_flag), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
  );
endmodule

// File: tb/evt_timer_tb_top.sv
`timescale 1ns/1ps
module evt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_evt = 1'b0, psc_tick = 1'b0, wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [23:0] wr_data = 24'h0;
  logic [23:0] rd_data;
  logic        ack_ovf = 1'b0, ack_cmp = 1'b0;
  logic        ovf_flag, cmp_flag, irq_ovf, irq_cmp;

  int    n_chk = 0, n_err = 0, cyc = 0;
  string cur_req = "R1";
  logic  cmp_on = 1'b0;

  always #10 clk = ~clk;

  evt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ext_evt(ext_evt), .psc_tick(psc_tick),
    .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
    .ack_ovf(ack_ovf), .ack_cmp(ack_cmp), .ovf_flag(ovf_flag),
    .cmp_flag(cmp_flag), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  logic [23:0] m_cnt, m_ld, m_cv, nc;
  logic m_en, m_io, m_ic, m_ex, m_ps, m_of, m_cf;
  logic e1, e2, e3, ev, wc, so, sc, nof, ncf;
  int   m_cyc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ld = 0; m_cv = 0;
      m_en = 0; m_io = 0; m_ic = 0; m_ex = 0; m_ps = 0; m_of = 0; m_cf = 0;
      e1 = 0; e2 = 0; e3 = 0; m_cyc = 0;
    end else begin
      if (m_ps)      ev = psc_tick;
      else if (m_ex) ev = e2 && !e3;
      else           ev = m_en && (m_cyc % 2 == 1);
      wc = wr_en && (reg_sel == 2'd0);
      so = 0; sc = 0; nc = m_cnt;
      if (m_en && ev) begin
        if (m_cnt == m_cv) begin sc = 1; nc = m_ld; end
        else if (m_cnt == 24'hFFFFFF) begin so = 1; nc = 24'h0; end
        else nc = m_cnt + 24'd1;
      end
      if (wc && wr_data[0] && !m_en) nc = m_ld;
      nof = m_of; ncf = m_cf;
      if ((wc && wr_data[20]) || ack_ovf) nof = 0;
      if ((wc && wr_data[21]) || ack_cmp) ncf = 0;
      if (so) nof = 1;
      if (sc) ncf = 1;
      if (wc && !wr_data[0]) begin nof = 0; ncf = 0; end
      m_cyc = m_en ? m_cyc + 1 : 0;
      if (wc) begin
        m_en = wr_data[0]; m_io = wr_data[1]; m_ic = wr_data[2];
        m_ex = wr_data[4]; m_ps = wr_data[15];
      end
      if (wr_en && reg_sel == 2'd1) m_ld = wr_data;
      if (wr_en && reg_sel == 2'd2) m_cv = wr_data;
      m_cnt = nc; m_of = nof; m_cf = ncf;
      e3 = e2; e2 = e1; e1 = ext_evt;
    end
  end

  function automatic logic [23:0] exp_rd(input logic [1:0] s);
    logic [23:0] c;
    c = 24'h0;
    c[0] = m_en; c[1] = m_io; c[2] = m_ic; c[4] = m_ex; c[15] = m_ps;
    c[20] = m_of; c[21] = m_cf;
    case (s)
      2'd0: return c;
      2'd1: return m_ld;
      2'd2: return m_cv;
      default: return m_cnt;
    endcase
  endfunction

  // compare against the model every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(cur_req, {23'h0, ovf_flag}, {23'h0, m_of});
      chk(cur_req, {23'h0, cmp_flag}, {23'h0, m_cf});
      chk("R11", {23'h0, irq_ovf}, {23'h0, m_of & m_io});
      chk("R11", {23'h0, irq_cmp}, {23'h0, m_cf & m_ic});
      chk(cur_req, rd_data, exp_rd(reg_sel));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [23:0] d);
    wr_en = 1'b1; reg_sel = s; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = 24'h0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {22'h0, irq_ovf, irq_cmp}, 24'h0);
    chk("R1", {22'h0, ovf_flag, cmp_flag}, 24'h0);
    chk("R1", rd_data, 24'h0);
    cmp_on = 1'b1;
    step(1);
    reg_sel = 2'd3; step(1);
    reg_sel = 2'd1; step(1);

    // R12 readback of start and match values
    cur_req = "R12";
    wr(2'd1, 24'h000005);
    wr(2'd2, 24'h000009);
    wr(2'd3, 24'h00ABCD);
    reg_sel = 2'd1; @(negedge clk); chk("R12", rd_data, 24'h000005);
    step(1);
    reg_sel = 2'd2; @(negedge clk); chk("R12", rd_data, 24'h000009);
    step(1);

    // R2 reserved bits ignored; flag bits written as one do nothing while off
    cur_req = "R2";
    wr(2'd0, 24'hFFFFFE);
    reg_sel = 2'd0; @(negedge clk); chk("R2", rd_data, 24'h008016);
    step(1);
    wr(2'd0, 24'h000000);

    // R3 / R5 internal half-rate source, match after N-M+1 events
    cur_req = "R5";
    wr(2'd0, 24'h000007);
    reg_sel = 2'd3; @(negedge clk); chk("R3", rd_data, 24'h000005);
    step(14);
    chk("R5", {23'h0, cmp_flag}, 24'h1);
    // R7 write zero keeps the flag, write one clears it
    cur_req = "R7";
    wr(2'd0, 24'h100007);
    step(2);
    wr(2'd0, 24'h200007);
    step(12);
    // R8 acknowledge
    cur_req = "R8";
    ack_cmp = 1'b1; step(1); ack_cmp = 1'b0;
    step(4);

    // R6 wrap from all ones, prescaler source
    cur_req = "R6";
    wr(2'd0, 24'h000000);
    wr(2'd1, 24'hFFFFFC);
    wr(2'd2, 24'h000010);
    wr(2'd0, 24'h008007);
    reg_sel = 2'd3;
    psc_tick = 1'b1; step(6); psc_tick = 1'b0;
    @(negedge clk); chk("R6", {23'h0, ovf_flag}, 24'h1);
    step(1);
    cur_req = "R8";
    ack_ovf = 1'b1; step(1); ack_ovf = 1'b0;
    @(negedge clk); chk("R8", {23'h0, ovf_flag}, 24'h0);
    step(1);

    // R6 match at all ones reloads, no wrap; R11 with interrupts off
    cur_req = "R6";
    wr(2'd0, 24'h000000);
    wr(2'd1, 24'hFFFFFE);
    wr(2'd2, 24'hFFFFFF);
    wr(2'd0, 24'h008011);
    psc_tick = 1'b1; step(6); psc_tick = 1'b0;
    @(negedge clk);
    chk("R6", {23'h0, ovf_flag}, 24'h0);
    chk("R6", {23'h0, cmp_flag}, 24'h1);
    chk("R11", {23'h0, irq_cmp}, 24'h0);
    step(1);

    // R9 turning the channel off clears both flags
    cur_req = "R9";
    wr(2'd0, 24'h000000);
    @(negedge clk); chk("R9", {22'h0, ovf_flag, cmp_flag}, 24'h0);
    step(1);

    // R4 external source
    cur_req = "R4";
    wr(2'd1, 24'h000000);
    wr(2'd2, 24'h000002);
    wr(2'd0, 24'h000015);
    for (int k = 0; k < 4; k++) begin
      ext_evt = 1'b1; step(3);
      ext_evt = 1'b0; step(3);
    end
    step(4);
    chk("R4", {23'h0, cmp_flag}, 24'h1);
    // R4 prescaler overrides external select
    wr(2'd0, 24'h008015);
    ext_evt = 1'b1; step(3); ext_evt = 1'b0;
    psc_tick = 1'b1; step(2); psc_tick = 1'b0;
    step(3);

    // R10 event set beats simultaneous acknowledge and write-one clear
    cur_req = "R10";
    wr(2'd0, 24'h000000);
    wr(2'd1, 24'h000003);
    wr(2'd2, 24'h000003);
    wr(2'd0, 24'h008005);
    psc_tick = 1'b1; ack_cmp = 1'b1; step(3);
    @(negedge clk); chk("R10", {23'h0, cmp_flag}, 24'h1);
    step(1);
    wr(2'd0, 24'h208005);
    ack_cmp = 1'b0;
    @(negedge clk); chk("R10", {23'h0, cmp_flag}, 24'h1);
    step(1);
    psc_tick = 1'b0;
    // R9 turn-off clear wins over a same-cycle set
    cur_req = "R9";
    psc_tick = 1'b1; wr(2'd0, 24'h008004); psc_tick = 1'b0;
    @(negedge clk); chk("R9", {23'h0, cmp_flag}, 24'h0);
    step(3);

    finish_run();
  end
endmodule